// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts rendered scanlines by watching rising edges of the video address line A12. It raises a level interrupt request to the CPU when a programmed count runs out. The CPU sets it up through four register writes: it loads a reload value, zeroes the counter, enables the interrupt, and disables the interrupt while acknowledging a pending request. The request stays asserted until software acknowledges it.

A12 arrives from another clock domain and toggles briefly during sprite fetches. The block therefore passes it through a synchroniser and accepts a rising edge only after the line has been low for a minimum number of clocks. A strap input picks one of two zero-crossing rules. The standard rule fires whenever the counter ends an edge at zero. The alternate rule fires only when the counter steps down from a nonzero value to zero, or when a reload was forced by the clear register.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write with `wr_sel` = 0 stores `wr_data` as the reload value. It has no other effect.
- R2: A write with `wr_sel` = 1 sets the counter to 0. When `alt_mode` = 1, it also arms a pending-reload flag that forces a reload on the next accepted edge.
- R3: A write with `wr_sel` = 2 disables the interrupt and drops `irq_o` in the following cycle.
- R4: A write with `wr_sel` = 3 enables the interrupt.
- R5: On each accepted A12 rising edge, the counter loads the reload value if it is 0 or if the pending-reload flag is set. Otherwise it decrements by one. Every accepted edge clears the pending-reload flag.
- R6: With `alt_mode` = 0, `irq_o` is set after an accepted edge that leaves the counter at 0 while the interrupt is enabled. A reload of value 0 also counts.
- R7: With `alt_mode` = 1, `irq_o` is set only when the edge leaves the counter at 0, the interrupt is enabled, and either the counter was nonzero before the edge or the pending-reload flag was set.
- R8: `irq_o` is sticky. Only a `wr_sel` = 2 write or reset clears it.
- R9: After reset, the reload value is 255, the counter is 0, the interrupt is disabled, the pending flag is clear, and `irq_o` is 0.
- R10: A12 is synchronised to `clk`. A rising edge is accepted only if the synchronised line was low for at least `LOW_MIN` clocks (default 4) before it. Shorter low pulses have no effect on the counter.
- R11: While the interrupt is disabled, accepted edges still update the counter but never set `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register select: 0 reload, 1 clear, 2 disable/ack, 3 enable |
| wr_data | input | CNT_W | Write data (reload value) |
| a12_in | input | 1 | Asynchronous video address line A12 |
| alt_mode | input | 1 | Revision strap: 0 standard rule, 1 alternate rule |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The bench sweeps both revision rules against a range of reload values, including the reload value 0. Under the standard rule a reload of 0 fires on every edge. Under the alternate rule it fires only after a clear, so a design that merges the two rules fails on the first edge. Low pulses of exactly `LOW_MIN` clocks and of one clock fewer probe the filter boundary; an off-by-one filter either drops the first or counts the second. A full 256-edge run from reset with the default reload shows whether the reset value or the decrement wrap is wrong. Edges taken while the interrupt is disabled reveal whether counting wrongly stops or the request leaks out.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD  = 2'd0,
    SEL_CLEAR   = 2'd1,
    SEL_DISABLE = 2'd2,
    SEL_ENABLE  = 2'd3
  } irq_sel_e;
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12_in,
  output logic rise_o
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [LW-1:0]          low_q, low_d;
  logic                   a12_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= a12_in;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign a12_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    low_d = low_q;
    if (a12_s)                low_d = '0;
    else if (low_q != LOW_SAT) low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b0;
      low_q  <= '0;
    end else begin
      prev_q <= a12_s;
      low_q  <= low_d;
    end

  assign rise_o = a12_s && !prev_q && (low_q == LOW_SAT);

  // R10: an accepted edge is a single-cycle pulse
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irq_fire_rule.sv
module irq_fire_rule #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_before,
  input  logic [CNT_W-1:0] cnt_after,
  input  logic             pend,
  input  logic             enabled,
  input  logic             alt_mode,
  output logic             fire_o
);
  logic hit_zero;
  logic alt_ok;

  assign hit_zero = (cnt_after == '0);
  assign alt_ok   = (cnt_before != '0) || pend;
  assign fire_o   = hit_zero && enabled && (!alt_mode || alt_ok);
endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             alt_mode,
  input  logic             edge_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d, step_val;
  logic             en_q, en_d, pend_q, pend_d, irq_q, irq_d;
  logic             fire;
  irq_sel_e         sel;

  assign sel      = irq_sel_e'(wr_sel);
  assign step_val = ((cnt_q == '0) || pend_q) ? rld_q : cnt_q - 1'b1;

  irq_fire_rule #(.CNT_W(CNT_W)) i_rule (
    .cnt_before (cnt_q),
    .cnt_after  (step_val),
    .pend       (pend_q),
    .enabled    (en_q),
    .alt_mode   (alt_mode),
    .fire_o     (fire)
  );

  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    en_d   = en_q;
    pend_d = pend_q;
    irq_d  = irq_q;
    if (edge_i) begin
      cnt_d  = step_val;
      pend_d = 1'b0;
      if (fire) irq_d = 1'b1;
    end
    if (wr_en) begin
      unique case (sel)
        SEL_RELOAD:  rld_d = wr_data;
        SEL_CLEAR: begin
          cnt_d = '0;
          if (alt_mode) pend_d = 1'b1;
        end
        SEL_DISABLE: begin
          en_d  = 1'b0;
          irq_d = 1'b0;
        end
        SEL_ENABLE:  en_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '1;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end

  assign irq_o = irq_q;

  assert_ack_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> !irq_q);
  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (cnt_q == '0));
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(wr_en && wr_sel == 2'd2)) |=> irq_q);
  assert_irq_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !edge_i) |=> !irq_q);
  assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !irq_q) |=> !irq_q);
  assert_pend_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !(wr_en && wr_sel == 2'd1)) |=> !pend_q);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int CNT_W       = 8,
  parameter int LOW_MIN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             a12_in,
  input  logic             alt_mode,
  output logic             irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       a12_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};

  assign rst_int_n = rst_sync_q[1];

  a12_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) i_filter (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .a12_in (a12_in),
    .rise_o (a12_rise)
  );

  irq_down_counter #(.CNT_W(CNT_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .alt_mode (alt_mode),
    .edge_i   (a12_rise),
    .irq_o    (irq_o)
  );

  // R9: request is low while held in reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_int_n |-> !irq_o);
endmodule

// File: tb/test_scanline_irq_counter.sv
module test_scanline_irq_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_MIN    = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       a12_in;
  logic       alt_mode;
  logic       irq_o;

  int tests = 0;
  int fails = 0;

  // bench reference state
  int  m_cnt, m_rld;
  bit  m_en, m_pend, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_irq_counter i_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .a12_in(a12_in), .alt_mode(alt_mode), .irq_o(irq_o)
  );

  task automatic check(input string req, input bit exp);
    tests++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq_o, exp, $time);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    case (sel)
      0: m_rld = data;
      1: begin m_cnt = 0; if (alt_mode) m_pend = 1; end
      2: begin m_en = 0; m_irq = 0; end
      default: m_en = 1;
    endcase
  endtask

  task automatic model_edge();
    int old;
    old = m_cnt;
    if (m_cnt == 0 || m_pend) m_cnt = m_rld; else m_cnt = m_cnt - 1;
    if (m_cnt == 0 && m_en && (!alt_mode || old != 0 || m_pend)) m_irq = 1;
    m_pend = 0;
  endtask

  // low for lo cycles then high; edge counted when lo >= LOW_MIN
  task automatic pulse(input int lo);
    @(negedge clk);
    a12_in = 1'b0;
    repeat (lo) @(negedge clk);
    a12_in = 1'b1;
    repeat (6) @(negedge clk);
    if (lo >= LOW_MIN) model_edge();
  endtask

  task automatic do_reset();
    a12_in = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt = 0; m_rld = 255; m_en = 0; m_pend = 0; m_irq = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    alt_mode = 1'b0;
    do_reset();
    check("R9 reset irq low", 1'b0);

    // R9: default reload 255 -> first edge loads 255, then 255 steps to zero
    wr(3, 0);
    pulse(LOW_MIN + 1);
    check("R9 reload 255 first edge", 1'b0);
    for (int i = 1; i < 256; i++) begin
      pulse(LOW_MIN + 1);
      if (i == 254) check("R5 one step before zero", m_irq);
    end
    check("R6 irq after 256 edges", 1'b1);
    check("R6 model agreement", m_irq);

    // R10 boundary: LOW_MIN-1 ignored, LOW_MIN accepted (reload 0 fires every edge)
    wr(2, 0); wr(0, 0); wr(1, 0); wr(3, 0);
    pulse(LOW_MIN - 1);
    check("R10 short low ignored", 1'b0);
    pulse(1);
    check("R10 one-clock glitch ignored", 1'b0);
    pulse(LOW_MIN);
    check("R10 LOW_MIN low accepted", 1'b1);

    // R8 sticky across further edges and a reload write
    wr(0, 7);
    check("R1 reload write no side effect", 1'b1);
    pulse(LOW_MIN + 1);
    check("R8 sticky", 1'b1);
    wr(2, 0);
    check("R3 ack drops irq", 1'b0);

    // sweep both rules and several reload values
    for (int alt = 0; alt < 2; alt++) begin
      for (int r = 0; r < 6; r++) begin
        alt_mode = alt[0];
        wr(2, 0); wr(0, r); wr(1, 0); wr(3, 0);
        for (int k = 0; k < 14; k++) begin
          if (k == 7) wr(1, 0);
          pulse(LOW_MIN + 2);
          if (alt) check("R7 alt rule sweep", m_irq);
          else     check("R6 std rule sweep", m_irq);
          if (m_irq) begin
            wr(2, 0);
            check("R3 ack in sweep", 1'b0);
            wr(3, 0);
            check("R4 enable keeps irq low until edge", 1'b0);
          end
        end
      end
    end

    // R7: alt mode, reload 0 without clear never fires; with clear fires once
    alt_mode = 1'b1;
    wr(2, 0); wr(0, 0); wr(3, 0);
    pulse(LOW_MIN + 1); pulse(LOW_MIN + 1);
    check("R7 alt reload-to-zero silent", 1'b0);
    wr(1, 0);
    pulse(LOW_MIN + 1);
    check("R2 R7 clear forces firing reload", 1'b1);

    // R11: disabled counting continues silently
    alt_mode = 1'b0;
    wr(2, 0); wr(0, 3); wr(1, 0);
    for (int k = 0; k < 3; k++) pulse(LOW_MIN + 1);
    check("R11 disabled no irq", 1'b0);
    wr(3, 0);
    pulse(LOW_MIN + 1);
    check("R11 counter advanced while disabled", m_irq);
    check("R11 fires at zero after enable", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule